// File: doc/BRIEF.md
# Pipelined Run-Time Rotate-Left Unit

This block rotates a data word left by an amount supplied with each operand. Bits pushed out of the most significant end come back in at the least significant end. The rotation is split into a chain of registered mux stages. Each stage handles one digit of the amount. A digit is one bit when `RADIX` is 2, or two bits when `RADIX` is 4. Each output bit therefore passes through one small mux per cycle, not one wide mux in a single cycle.

The unit takes a new operand on every clock that `in_vld` is high. It returns the rotated word with `out_vld` after a fixed number of cycles. There is no stall and no backpressure. Each stage also registers the full amount field, so every stage acts on the control bits of its own operand even when operands arrive back to back. Reset is active low and asynchronous, and its release is expected to be synchronous to `clk`. Reset clears only the valid bits; data registers are not reset.

Top module: `rotl_pipe`

## Requirements
- R1: When `out_vld` is high, `out_dat` equals the input word rotated left by the amount sent with it: `(d << a) | (d >> (WIDTH-a))`. Bit WIDTH-1 wraps to bit 0.
- R2: Every amount from 0 to WIDTH-1 is supported. An amount of 0 returns the word unchanged.
- R3: The latency is ceil(log2(WIDTH)/log2(RADIX)) cycles. That is 5 cycles for WIDTH=32 with RADIX=2, and 3 cycles with RADIX=4.
- R4: Operands may arrive on consecutive cycles or with idle gaps between them. Each result uses only its own operand's word and amount.
- R5: `out_vld` is high exactly once for each cycle that `in_vld` was high, exactly the latency later. It is never high at any other time.
- R6: Driving `rst_n` low clears every valid bit at once. Operands in flight are discarded, and `out_vld` stays low until a new operand has travelled through the pipeline.
- R7: No stage creates or loses bits: each stage's registered word has the same number of ones as its input word.
- R8: `RADIX` may be 2 or 4. Both variants give the same results and differ only in latency.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_vld | input | 1 | Operand strobe |
| in_dat | input | WIDTH | Word to rotate |
| in_amt | input | $clog2(WIDTH) | Left-rotate amount |
| out_vld | output | 1 | Result strobe |
| out_dat | output | WIDTH | Rotated word |

## Verification
The main function is driven by a table of hand-computed vectors covering amounts 0, 1, WIDTH-1, powers of two and odd mixed values. Data patterns are chosen so that a wrong wrap, a wrong direction or a swapped nibble gives a visibly different word. A walking single one across all 32 amounts separates the stages, since each amount bit moves the one by a distinct distance. A word with both end bits set across all amounts exposes errors at the wrap boundary. The table is replayed back to back and again with idle gaps, on both a radix-2 and a radix-4 instance, so a stage that uses the wrong operand's control bits or the wrong latency is caught. A reset in the middle of a stream shows that operands in flight are dropped.

// File: rtl/rotl_pkg.sv
package rotl_pkg;

  // number of amount bits consumed by one stage
  function automatic int dig_bits(input int radix);
    return (radix == 4) ? 2 : 1;
  endfunction

  // number of registered stages for a given amount width
  function automatic int n_stages(input int amt_w, input int dig_w);
    return (amt_w + dig_w - 1) / dig_w;
  endfunction

endpackage

// File: rtl/rotl_rot_mux.sv
module rotl_rot_mux #(
  parameter int WIDTH = 32,
  parameter int DIG_W = 1,
  parameter int STEP  = 1
) (
  input  logic [WIDTH-1:0] dat_i,
  input  logic [DIG_W-1:0] digit_i,
  output logic [WIDTH-1:0] rot_o
);

  localparam int NCAND = 1 << DIG_W;

  logic [WIDTH-1:0] cand [NCAND];

  // each candidate is a fixed rotation: wiring only, no logic
  for (genvar j = 0; j < NCAND; j++) begin : g_cand
    localparam int SH = (j * STEP) % WIDTH;
    if (SH == 0) begin : g_id
      assign cand[j] = dat_i;
    end else begin : g_rot
      assign cand[j] = {dat_i[WIDTH-1-SH:0], dat_i[WIDTH-1 -: SH]};
    end
  end

  always_comb begin
    rot_o = cand[digit_i];
  end

endmodule

// File: rtl/rotl_stage.sv
module rotl_stage #(
  parameter int WIDTH = 32,
  parameter int PAD_W = 5,
  parameter int DIG_W = 1,
  parameter int STG   = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             vld_i,
  input  logic [WIDTH-1:0] dat_i,
  input  logic [PAD_W-1:0] amt_i,
  output logic             vld_o,
  output logic [WIDTH-1:0] dat_o,
  output logic [PAD_W-1:0] amt_o
);

  localparam int BASE = STG * DIG_W;
  localparam int STEP = 1 << BASE;

  logic [DIG_W-1:0] digit;
  logic [WIDTH-1:0] dat_nxt;
  logic             vld_q;
  logic [WIDTH-1:0] dat_q;
  logic [PAD_W-1:0] amt_q;

  assign digit = amt_i[BASE +: DIG_W];

  rotl_rot_mux #(
    .WIDTH (WIDTH),
    .DIG_W (DIG_W),
    .STEP  (STEP)
  ) u_mux (
    .dat_i   (dat_i),
    .digit_i (digit),
    .rot_o   (dat_nxt)
  );

  // valid bit: the only reset flop of the stage
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_i;
    end
  end

  // payload: loaded only with a valid operand
  always_ff @(posedge clk) begin
    if (vld_i) begin
      dat_q <= dat_nxt;
      amt_q <= amt_i;
    end
  end

  assign vld_o = vld_q;
  assign dat_o = dat_q;
  assign amt_o = amt_q;

  // R7: a rotation keeps the population count
  a_r7_bits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> ($countones(dat_q) == $countones($past(dat_i))));

  // R2: a zero digit passes the word unchanged
  a_r2_zero_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_q && ($past(digit) == '0)) |-> (dat_q == $past(dat_i)));

  // R4: control bits travel with their own operand
  a_r4_amt_follows: assert property (@(posedge clk) disable iff (!rst_n)
    vld_q |-> (amt_q == $past(amt_i)));

endmodule

// File: rtl/rotl_pipe.sv
module rotl_pipe #(
  parameter int  WIDTH = 32,
  parameter int  RADIX = 2,
  localparam int AMT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_vld,
  input  logic [WIDTH-1:0] in_dat,
  input  logic [AMT_W-1:0] in_amt,
  output logic             out_vld,
  output logic [WIDTH-1:0] out_dat
);

  localparam int DIG_W = rotl_pkg::dig_bits(RADIX);
  localparam int NSTG  = rotl_pkg::n_stages(AMT_W, DIG_W);
  localparam int PAD_W = NSTG * DIG_W;
  localparam int CNT_W = $clog2(NSTG + 2);

  logic [NSTG:0]            vld_c;
  logic [NSTG:0][WIDTH-1:0] dat_c;
  logic [NSTG:0][PAD_W-1:0] amt_c;

  assign vld_c[0] = in_vld;
  assign dat_c[0] = in_dat;
  assign amt_c[0] = PAD_W'(in_amt);

  for (genvar s = 0; s < NSTG; s++) begin : g_stg
    rotl_stage #(
      .WIDTH (WIDTH),
      .PAD_W (PAD_W),
      .DIG_W (DIG_W),
      .STG   (s)
    ) u_stage (
      .clk   (clk),
      .rst_n (rst_n),
      .vld_i (vld_c[s]),
      .dat_i (dat_c[s]),
      .amt_i (amt_c[s]),
      .vld_o (vld_c[s+1]),
      .dat_o (dat_c[s+1]),
      .amt_o (amt_c[s+1])
    );
  end

  assign out_vld = vld_c[NSTG];
  assign out_dat = dat_c[NSTG];

  logic unused_amt;
  assign unused_amt = ^amt_c[NSTG];

  // in-flight counter for the pipeline-level checks
  logic [CNT_W-1:0] inflight_q;
  logic [CNT_W-1:0] inflight_nxt;

  always_comb begin
    inflight_nxt = inflight_q + CNT_W'(in_vld) - CNT_W'(out_vld);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inflight_q <= '0;
    end else begin
      inflight_q <= inflight_nxt;
    end
  end

  // R5: no result appears without an accepted operand
  a_r5_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> (inflight_q != '0));

  // R3: never more operands in flight than stages
  a_r3_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    inflight_q <= CNT_W'(NSTG));

endmodule

// File: tb/rotl_pipe_test.sv
module rotl_pipe_test;

  localparam int W    = 32;
  localparam int LAT2 = 5;
  localparam int LAT4 = 3;
  localparam int NV   = 14;

  localparam logic [31:0] VD [NV] = '{
    32'h00000001, 32'h00000001, 32'h80000000, 32'h12345678,
    32'h12345678, 32'h12345678, 32'h80000001, 32'hF0000000,
    32'hDEADBEEF, 32'hA5A5A5A5, 32'h00000003, 32'h0000FFFF,
    32'h00000001, 32'h13579BDF};
  localparam logic [4:0] VA [NV] = '{
    5'd0, 5'd1, 5'd1, 5'd4, 5'd8, 5'd16, 5'd31, 5'd4,
    5'd12, 5'd1, 5'd30, 5'd20, 5'd31, 5'd28};
  localparam logic [31:0] VE [NV] = '{
    32'h00000001, 32'h00000002, 32'h00000001, 32'h23456781,
    32'h34567812, 32'h56781234, 32'hC0000000, 32'h0000000F,
    32'hDBEEFDEA, 32'h4B4B4B4B, 32'hC0000000, 32'hFFF0000F,
    32'h80000000, 32'hF13579BD};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_vld = 1'b0;
  logic [31:0] in_dat = '0;
  logic [4:0]  in_amt = '0;
  logic        out_vld2, out_vld4;
  logic [31:0] out_dat2, out_dat4;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;

  logic [31:0] q2_d[$];
  int          q2_t[$];
  logic [31:0] q4_d[$];
  int          q4_t[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  rotl_pipe #(.WIDTH(W), .RADIX(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .in_amt(in_amt), .out_vld(out_vld2), .out_dat(out_dat2));

  rotl_pipe #(.WIDTH(W), .RADIX(4)) uut_r4 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_dat(in_dat),
    .in_amt(in_amt), .out_vld(out_vld4), .out_dat(out_dat4));

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [31:0] d, input logic [4:0] a,
                      input logic [31:0] e);
    @(negedge clk); #1;
    in_vld = 1'b1; in_dat = d; in_amt = a;
    q2_d.push_back(e); q2_t.push_back(cyc);
    q4_d.push_back(e); q4_t.push_back(cyc);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #1;
      in_vld = 1'b0; in_dat = 32'hX5A5_0000 ^ i; in_amt = 5'(i);
    end
  endtask

  // radix-2 result monitor (R1, R3, R5)
  always @(negedge clk) begin
    if (rst_n && out_vld2) begin
      if (q2_d.size() == 0) begin
        chk(1'b0, "R5 radix2 unexpected out_vld", 32'h1, 32'h0);
      end else begin
        logic [31:0] e; int t;
        e = q2_d.pop_front(); t = q2_t.pop_front();
        chk(out_dat2 === e, "R1 radix2 data", out_dat2, e);
        chk(cyc - t == LAT2, "R3 radix2 latency", 32'(cyc - t), 32'(LAT2));
      end
    end
  end

  // radix-4 result monitor (R8, R3, R5)
  always @(negedge clk) begin
    if (rst_n && out_vld4) begin
      if (q4_d.size() == 0) begin
        chk(1'b0, "R5 radix4 unexpected out_vld", 32'h1, 32'h0);
      end else begin
        logic [31:0] e; int t;
        e = q4_d.pop_front(); t = q4_t.pop_front();
        chk(out_dat4 === e, "R8 radix4 data", out_dat4, e);
        chk(cyc - t == LAT4, "R3 radix4 latency", 32'(cyc - t), 32'(LAT4));
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R6: outputs idle in reset
    repeat (3) @(negedge clk);
    chk(out_vld2 == 1'b0, "R6 reset valid radix2", 32'(out_vld2), 32'h0);
    chk(out_vld4 == 1'b0, "R6 reset valid radix4", 32'(out_vld4), 32'h0);
    #1 rst_n = 1'b1;
    idle(2);

    // R1/R4: table back to back
    for (int i = 0; i < NV; i++) send(VD[i], VA[i], VE[i]);
    idle(1);
    // R4: table with idle gaps
    for (int i = 0; i < NV; i++) begin
      send(VD[i], VA[i], VE[i]);
      idle(i % 3);
    end
    idle(1);

    // R2: walking one over every amount
    for (int a = 0; a < W; a++) send(32'h1, 5'(a), 32'h1 << a);
    // R1: both end bits set, wrap over every amount
    for (int a = 0; a < W; a++)
      send(32'h80000001, 5'(a),
           (32'h1 << a) | ((a == 0) ? 32'h80000000 : (32'h1 << (a - 1))));
    idle(LAT2 + 3);
    // R5: every accepted operand produced exactly one result
    chk(q2_d.size() == 0, "R5 radix2 drained", 32'(q2_d.size()), 32'h0);
    chk(q4_d.size() == 0, "R5 radix4 drained", 32'(q4_d.size()), 32'h0);

    // R6: reset in the middle of a stream drops in-flight operands
    send(32'hCAFEF00D, 5'd3, 32'h0);
    send(32'h0F0F0F0F, 5'd9, 32'h0);
    @(negedge clk); #1;
    in_vld = 1'b0; rst_n = 1'b0;
    q2_d.delete(); q2_t.delete(); q4_d.delete(); q4_t.delete();
    @(negedge clk);
    chk(out_vld2 == 1'b0, "R6 mid-stream reset radix2", 32'(out_vld2), 32'h0);
    chk(out_vld4 == 1'b0, "R6 mid-stream reset radix4", 32'(out_vld4), 32'h0);
    #1 rst_n = 1'b1;
    for (int i = 0; i < LAT2 + 2; i++) begin
      @(negedge clk);
      chk(out_vld2 == 1'b0, "R6 quiet after reset radix2", 32'(out_vld2), 32'h0);
      chk(out_vld4 == 1'b0, "R6 quiet after reset radix4", 32'(out_vld4), 32'h0);
    end

    // R1/R8: pipeline works again after reset
    send(32'h12345678, 5'd4, 32'h23456781);
    idle(LAT2 + 3);
    chk(q2_d.size() == 0, "R5 radix2 after reset", 32'(q2_d.size()), 32'h0);
    chk(q4_d.size() == 0, "R5 radix4 after reset", 32'(q4_d.size()), 32'h0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule